// File: doc/BRIEF.md
# SPI Byte Queues with Level-Triggered Interrupts

This block holds the two byte queues of a serial peripheral controller: a transmit queue that software fills and the serial shifter drains, and a receive queue that the shifter fills and software drains. Each queue reports its fill count. The count is compared against a trigger level that software programs, and the comparison raises a "receive data ready" request or a "transmit wants data" request.

The block also flags a receive overflow and records the end of a transfer. All four interrupt causes are kept in a sticky status vector. Software clears a bit by writing one to it. A level-type bit that is cleared while its condition still holds comes back one cycle later. This lets software drain or refill a queue first and then acknowledge it, without missing a request.

The interrupt line is the OR of the status bits that the enable vector lets through. Register decode and the shifter sit outside this block. They connect through a control-write strobe, a clear vector and simple push/pop ports. Pop data is the current head of a queue; it is valid whenever that queue is not empty.

Top module: `spi_queue_irq`

## Requirements
- R1: While reset is held and right after it, both queue counts are 0, `intStatus` is 0, `irq` is 0 and both trigger levels are 0.
- R2: Each queue returns bytes in the order they were accepted. The pop port shows the head combinationally. `fifoStatus` bits 6:0 carry the receive count and bits 22:16 carry the transmit count, one cycle after the push or pop edge. All other bits of `fifoStatus` are 0.
- R3: A push into a full queue is dropped. A dropped receive push sets status bit 8 (receive overflow) on the next edge; a dropped transmit push sets no flag. A pop of an empty queue changes nothing.
- R4: A cycle with `ctlWr` high loads the receive trigger level from `ctlData[7:0]` and the transmit trigger level from `ctlData[23:16]`.
- R5: Status bit 0 (receive ready) is set on any edge at which the receive count seen before that edge is nonzero and at or above the receive trigger level.
- R6: Status bit 4 (transmit request) is set on any edge at which the transmit count seen before that edge is at or below the transmit trigger level.
- R7: A one-cycle pulse on `xferDone` sets status bit 12 (transfer complete).
- R8: Status bits stay set until `statusClr` has a one in their position. Clearing a level bit (0 or 4) reads 0 for one cycle. The bit then sets again if its condition still holds.
- R9: When the event for bit 8 or bit 12 occurs in the same cycle as a clear of that bit, the bit ends up set.
- R10: `irq` is high exactly when some bit of `intStatus` is set and the same bit of `intEnable` is set.
- R11: A `ctlWr` cycle with `ctlData[15]` set empties the receive queue. A cycle with `ctlData[31]` set empties the transmit queue. A push or pop to a queue in its flush cycle is discarded, and that push raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWr | input | 1 | Control write strobe (trigger levels, flushes) |
| ctlData | input | 32 | Control write data |
| intEnable | input | 16 | Interrupt enable, same bit positions as status |
| statusClr | input | 16 | Write-one-to-clear pulse vector for status |
| xferDone | input | 1 | Transfer-complete pulse from the shifter |
| txPush | input | 1 | Software writes a byte into the transmit queue |
| txPushData | input | 8 | Byte to enqueue for transmit |
| txPop | input | 1 | Shifter takes the transmit head |
| txPopData | output | 8 | Transmit queue head |
| rxPush | input | 1 | Shifter delivers a received byte |
| rxPushData | input | 8 | Received byte |
| rxPop | input | 1 | Software reads the receive head |
| rxPopData | output | 8 | Receive queue head |
| fifoStatus | output | 32 | Receive count in 6:0, transmit count in 22:16 |
| intStatus | output | 16 | Sticky interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
A status clear can land in the same cycle as the condition or event that sets that bit. Level bits and event bits resolve this conflict in opposite directions. The bench drives `statusClr` together with a held receive-ready condition, and `statusClr` together with an `xferDone` pulse or an overflowing push. It expects a one-cycle dip for the level bit and no dip for the event bit. A flush in the same cycle as a push is the second collision exercised. There the expected result is an empty queue and no overflow flag.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  // interrupt cause positions, shared by status and enable
  localparam int INT_W        = 16;
  localparam int INT_RX_READY = 0;
  localparam int INT_TX_REQ   = 4;
  localparam int INT_RX_OVF   = 8;
  localparam int INT_DONE     = 12;

  // control word layout
  localparam int TRIG_W          = 8;
  localparam int CTL_RX_TRIG_LSB = 0;
  localparam int CTL_TX_TRIG_LSB = 16;
  localparam int CTL_RX_FLUSH    = 15;
  localparam int CTL_TX_FLUSH    = 31;

  // packed count layout
  localparam int STA_RX_CNT_LSB = 0;
  localparam int STA_TX_CNT_LSB = 16;
  localparam int STA_CNT_W      = 7;

  // queue indices inside the datapath
  localparam int Q_RX = 0;
  localparam int Q_TX = 1;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxFlush;
    logic txPush;
    logic txPop;
    logic txFlush;
  } qStrobes_t;
endpackage

// File: rtl/spiq_ring.sv
module spiq_ring #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign popData = mem[rdPtr];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN) count <= CW'(DEPTH)) else $error("count above depth"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) push |-> count != CW'(DEPTH)) else $error("push into full ring"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) pop |-> count != '0) else $error("pop of empty ring"); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN) flush |=> count == '0) else $error("flush left data"); // R11
endmodule

// File: rtl/spiq_datapath.sv
module spiq_datapath import spiq_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobes_t         strobes,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic [DATA_W-1:0] txPushData,
  output logic [DATA_W-1:0] rxPopData,
  output logic [DATA_W-1:0] txPopData,
  output logic [CW-1:0]     rxCount,
  output logic [CW-1:0]     txCount
);
  logic [1:0]        pushV, popV, flushV;
  logic [DATA_W-1:0] inD  [2];
  logic [DATA_W-1:0] outD [2];
  logic [CW-1:0]     cnt  [2];

  assign pushV[Q_RX]  = strobes.rxPush;
  assign pushV[Q_TX]  = strobes.txPush;
  assign popV[Q_RX]   = strobes.rxPop;
  assign popV[Q_TX]   = strobes.txPop;
  assign flushV[Q_RX] = strobes.rxFlush;
  assign flushV[Q_TX] = strobes.txFlush;
  assign inD[Q_RX]    = rxPushData;
  assign inD[Q_TX]    = txPushData;

  for (genvar gi = 0; gi < 2; gi++) begin : gQueue
    spiq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uRing (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushV[gi]),
      .pop      (popV[gi]),
      .flush    (flushV[gi]),
      .pushData (inD[gi]),
      .popData  (outD[gi]),
      .count    (cnt[gi])
    );
  end

  assign rxPopData = outD[Q_RX];
  assign txPopData = outD[Q_TX];
  assign rxCount   = cnt[Q_RX];
  assign txCount   = cnt[Q_TX];
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl import spiq_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic [31:0]      ctlData,
  input  logic [INT_W-1:0] intEnable,
  input  logic [INT_W-1:0] statusClr,
  input  logic             xferDone,
  input  logic             rxPushReq,
  input  logic             rxPopReq,
  input  logic             txPushReq,
  input  logic             txPopReq,
  input  logic [CW-1:0]    rxCount,
  input  logic [CW-1:0]    txCount,
  output qStrobes_t        strobes,
  output logic [INT_W-1:0] intStatus,
  output logic             irq
);
  localparam int CMPW = ((CW > TRIG_W) ? CW : TRIG_W) + 1;

  logic [TRIG_W-1:0] rxTrigQ, txTrigQ;
  logic              rxFlushNow, txFlushNow;
  logic              rxFull, txFull;
  logic              overflowEvt;
  logic              rxReadyCond, txReqCond;
  logic [INT_W-1:0]  setVec;
  logic [INT_W-1:0]  statusQ;

  // trigger levels
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxTrigQ <= '0;
      txTrigQ <= '0;
    end else if (ctlWr) begin
      rxTrigQ <= ctlData[CTL_RX_TRIG_LSB +: TRIG_W];
      txTrigQ <= ctlData[CTL_TX_TRIG_LSB +: TRIG_W];
    end
  end

  // queue strobes: flush wins, full and empty gate the requests
  assign rxFlushNow = ctlWr & ctlData[CTL_RX_FLUSH];
  assign txFlushNow = ctlWr & ctlData[CTL_TX_FLUSH];
  assign rxFull     = (rxCount == CW'(DEPTH));
  assign txFull     = (txCount == CW'(DEPTH));

  always_comb begin
    strobes.rxFlush = rxFlushNow;
    strobes.txFlush = txFlushNow;
    strobes.rxPush  = rxPushReq & ~rxFull & ~rxFlushNow;
    strobes.txPush  = txPushReq & ~txFull & ~txFlushNow;
    strobes.rxPop   = rxPopReq & (rxCount != '0) & ~rxFlushNow;
    strobes.txPop   = txPopReq & (txCount != '0) & ~txFlushNow;
  end

  assign overflowEvt = rxPushReq & rxFull & ~rxFlushNow;
  assign rxReadyCond = (rxCount != '0) && (CMPW'(rxCount) >= CMPW'(rxTrigQ));
  assign txReqCond   = (CMPW'(txCount) <= CMPW'(txTrigQ));

  always_comb begin
    setVec               = '0;
    setVec[INT_RX_READY] = rxReadyCond;
    setVec[INT_TX_REQ]   = txReqCond;
    setVec[INT_RX_OVF]   = overflowEvt;
    setVec[INT_DONE]     = xferDone;
  end

  // per-bit status: level bits let a clear win for one cycle,
  // event bits let the set win so no event is lost
  for (genvar b = 0; b < INT_W; b++) begin : gStatus
    if (b == INT_RX_READY || b == INT_TX_REQ) begin : gLevel
      always_ff @(posedge clk) begin
        if (!rstN)             statusQ[b] <= 1'b0;
        else if (statusClr[b]) statusQ[b] <= 1'b0;
        else                   statusQ[b] <= statusQ[b] | setVec[b];
      end
    end else if (b == INT_RX_OVF || b == INT_DONE) begin : gEvent
      always_ff @(posedge clk) begin
        if (!rstN) statusQ[b] <= 1'b0;
        else       statusQ[b] <= setVec[b] | (statusQ[b] & ~statusClr[b]);
      end
    end else begin : gSpare
      assign statusQ[b] = 1'b0;
    end
  end

  assign intStatus = statusQ;
  assign irq       = |(statusQ & intEnable);

  AST_RX_READY_SET: assert property (@(posedge clk) disable iff (!rstN) (rxReadyCond && !statusClr[INT_RX_READY]) |=> intStatus[INT_RX_READY]) else $error("rx ready missed"); // R5
  AST_TX_REQ_SET: assert property (@(posedge clk) disable iff (!rstN) (txReqCond && !statusClr[INT_TX_REQ]) |=> intStatus[INT_TX_REQ]) else $error("tx request missed"); // R6
  AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rstN) statusClr[INT_RX_READY] |=> !intStatus[INT_RX_READY]) else $error("level clear ignored"); // R8
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rstN) xferDone |=> intStatus[INT_DONE]) else $error("done lost"); // R9
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN) (rxPushReq && rxFull && !rxFlushNow) |=> intStatus[INT_RX_OVF]) else $error("overflow not flagged"); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN) (intStatus[INT_DONE] && !statusClr[INT_DONE]) |=> intStatus[INT_DONE]) else $error("status not sticky"); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN) (intEnable == '0) |-> !irq) else $error("irq while masked"); // R10
  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rstN) ctlWr |=> rxTrigQ == $past(ctlData[CTL_RX_TRIG_LSB +: TRIG_W])) else $error("trigger not loaded"); // R4
endmodule

// File: rtl/spi_queue_irq.sv
module spi_queue_irq import spiq_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [31:0]       ctlData,
  input  logic [INT_W-1:0]  intEnable,
  input  logic [INT_W-1:0]  statusClr,
  input  logic              xferDone,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  output logic [31:0]       fifoStatus,
  output logic [INT_W-1:0]  intStatus,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  qStrobes_t     strobes;
  logic [CW-1:0] rxCount, txCount;

  spiq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWr     (ctlWr),
    .ctlData   (ctlData),
    .intEnable (intEnable),
    .statusClr (statusClr),
    .xferDone  (xferDone),
    .rxPushReq (rxPush),
    .rxPopReq  (rxPop),
    .txPushReq (txPush),
    .txPopReq  (txPop),
    .rxCount   (rxCount),
    .txCount   (txCount),
    .strobes   (strobes),
    .intStatus (intStatus),
    .irq       (irq)
  );

  spiq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rxPushData (rxPushData),
    .txPushData (txPushData),
    .rxPopData  (rxPopData),
    .txPopData  (txPopData),
    .rxCount    (rxCount),
    .txCount    (txCount)
  );

  always_comb begin
    fifoStatus = '0;
    fifoStatus[STA_RX_CNT_LSB +: STA_CNT_W] = STA_CNT_W'(rxCount);
    fifoStatus[STA_TX_CNT_LSB +: STA_CNT_W] = STA_CNT_W'(txCount);
  end
endmodule

// File: tb/spi_queue_irq_test.sv
module spi_queue_irq_test;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWr = 0;
  logic [31:0] ctlData = '0;
  logic [15:0] intEnable = '0;
  logic [15:0] statusClr = '0;
  logic        xferDone = 0;
  logic        txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic [7:0]  txPushData = '0, rxPushData = '0;
  logic [7:0]  txPopData, rxPopData;
  logic [31:0] fifoStatus;
  logic [15:0] intStatus;
  logic        irq;

  int nChecks = 0;
  int nFail   = 0;

  logic [7:0]  rxQ[$];
  logic [7:0]  txQ[$];
  int          expRxTrig = 0, expTxTrig = 0;
  logic [15:0] expSt = '0;

  always #5 clk = ~clk;

  spi_queue_irq #(.DEPTH(DEPTH), .DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlData(ctlData),
    .intEnable(intEnable), .statusClr(statusClr), .xferDone(xferDone),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .fifoStatus(fifoStatus), .intStatus(intStatus), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] packCounts(input int rc, input int tc);
    logic [31:0] v;
    v = '0;
    v[6:0]   = 7'(rc);
    v[22:16] = 7'(tc);
    return v;
  endfunction

  // one clock: model next state from requirements, then compare
  task automatic step();
    logic rxFl, txFl, ovf, rdy, treq;
    int rc, tc;
    logic [15:0] ns;
    rxFl = ctlWr && ctlData[15];
    txFl = ctlWr && ctlData[31];
    rc = rxQ.size();
    tc = txQ.size();
    if (rxPop && !rxFl && rc > 0) chk("R2 rx head", {24'b0, rxPopData}, {24'b0, rxQ[0]});
    if (txPop && !txFl && tc > 0) chk("R2 tx head", {24'b0, txPopData}, {24'b0, txQ[0]});
    rdy  = (rc != 0) && (rc >= expRxTrig);
    treq = (tc <= expTxTrig);
    ovf  = rxPush && !rxFl && (rc == DEPTH);
    ns = '0;
    ns[0]  = statusClr[0] ? 1'b0 : (expSt[0] | rdy);
    ns[4]  = statusClr[4] ? 1'b0 : (expSt[4] | treq);
    ns[8]  = ovf | (expSt[8] & ~statusClr[8]);
    ns[12] = xferDone | (expSt[12] & ~statusClr[12]);
    if (rxFl) rxQ.delete();
    else begin
      if (rxPop && rc > 0) void'(rxQ.pop_front());
      if (rxPush && rc < DEPTH) rxQ.push_back(rxPushData);
    end
    if (txFl) txQ.delete();
    else begin
      if (txPop && tc > 0) void'(txQ.pop_front());
      if (txPush && tc < DEPTH) txQ.push_back(txPushData);
    end
    if (ctlWr) begin
      expRxTrig = int'(ctlData[7:0]);
      expTxTrig = int'(ctlData[23:16]);
    end
    @(posedge clk);
    #1;
    expSt = ns;
    ctlWr = 0; statusClr = '0; xferDone = 0;
    rxPush = 0; rxPop = 0; txPush = 0; txPop = 0;
    chk("R2 counts", fifoStatus, packCounts(rxQ.size(), txQ.size()));
    chk("R8 status", {16'b0, intStatus}, {16'b0, expSt});
    chk("R10 irq", {31'b0, irq}, {31'b0, |(expSt & intEnable)});
  endtask

  task automatic writeCtl(input logic [31:0] d);
    ctlWr = 1; ctlData = d; step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 counts", fifoStatus, 32'h0);
    chk("R1 status", {16'b0, intStatus}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rstN = 1;
    step();
    chk("R1 tx request after reset with trigger 0", {31'b0, intStatus[4]}, 32'h1);
    chk("R1 no rx ready with empty queue", {31'b0, intStatus[0]}, 32'h0);

    // R4 trigger load: rx 3, tx 2
    writeCtl(32'h0002_0003);
    statusClr = 16'hFFFF; step();
    for (int i = 0; i < 3; i++) begin
      rxPush = 1; rxPushData = 8'hA0 + 8'(i); step();
    end
    chk("R4 rx trigger 3 not yet reached", {31'b0, intStatus[0]}, 32'h0);
    step();
    chk("R5 rx ready at trigger", {31'b0, intStatus[0]}, 32'h1);

    // R8 clear while condition holds: dip then re-set
    statusClr = 16'h0001; step();
    chk("R8 cleared level bit reads 0", {31'b0, intStatus[0]}, 32'h0);
    step();
    chk("R8 level bit sets again", {31'b0, intStatus[0]}, 32'h1);

    // R7 / R9 done pulse with coincident clear
    xferDone = 1; step();
    chk("R7 done sets", {31'b0, intStatus[12]}, 32'h1);
    xferDone = 1; statusClr = 16'h1000; step();
    chk("R9 event beats clear", {31'b0, intStatus[12]}, 32'h1);
    statusClr = 16'h1000; step();
    chk("R8 done cleared", {31'b0, intStatus[12]}, 32'h0);

    // R10 masking
    intEnable = 16'h0000; step();
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    intEnable = 16'h0001; step();
    chk("R10 enabled irq", {31'b0, irq}, 32'h1);
    intEnable = 16'h0000;

    // R3 receive overflow and drain order
    while (rxQ.size() < DEPTH) begin
      rxPush = 1; rxPushData = 8'($urandom); step();
    end
    rxPush = 1; rxPushData = 8'h5A; statusClr = 16'h0100; step();
    chk("R3 full push dropped", {25'b0, fifoStatus[6:0]}, 32'(DEPTH));
    step();
    chk("R3 overflow flagged", {31'b0, intStatus[8]}, 32'h1);
    rxPush = 1; statusClr = 16'h0100; step();
    chk("R9 overflow beats clear", {31'b0, intStatus[8]}, 32'h1);
    while (rxQ.size() > 0) begin
      rxPop = 1; step();
    end
    rxPop = 1; step();
    chk("R3 pop of empty ignored", {25'b0, fifoStatus[6:0]}, 32'h0);

    // R3 transmit full push dropped without flag
    statusClr = 16'h0100; step();
    while (txQ.size() < DEPTH) begin
      txPush = 1; txPushData = 8'($urandom); step();
    end
    txPush = 1; txPushData = 8'hC3; step();
    step();
    chk("R3 tx full count", {25'b0, fifoStatus[22:16]}, 32'(DEPTH));
    chk("R3 tx drop sets no overflow", {31'b0, intStatus[8]}, 32'h0);
    statusClr = 16'h0010; step();
    step();
    chk("R6 tx request absent above trigger", {31'b0, intStatus[4]}, 32'h0);

    // R11 flush collides with push
    for (int i = 0; i < 4; i++) begin
      rxPush = 1; rxPushData = 8'(i); step();
    end
    rxPush = 1; rxPushData = 8'hEE; ctlWr = 1; ctlData = 32'h8002_8003; step();
    chk("R11 both queues flushed", fifoStatus, 32'h0);
    step();
    chk("R11 no overflow from flushed push", {31'b0, intStatus[8]}, 32'h0);
    chk("R6 tx request once empty", {31'b0, intStatus[4]}, 32'h1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      rxPush = ($urandom % 100) < 55; rxPushData = 8'($urandom);
      rxPop  = ($urandom % 100) < 40;
      txPush = ($urandom % 100) < 50; txPushData = 8'($urandom);
      txPop  = ($urandom % 100) < 45;
      xferDone = ($urandom % 100) < 5;
      if (($urandom % 100) < 15) statusClr = 16'($urandom) & 16'h1111;
      if (($urandom % 100) < 3) begin
        ctlWr = 1;
        ctlData = {($urandom % 20) == 0, 7'b0, 8'($urandom % 70),
                   ($urandom % 20) == 0, 7'b0, 8'($urandom % 70)};
      end
      if (($urandom % 100) < 5) intEnable = 16'($urandom) & 16'h1111;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule